// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Time advances on a one-second boundary produced by an internal prescaler. The prescaler counts `tick_en` pulses, and `TICKS_PER_SEC` sets how many pulses make one second. With the default of 32768 the input is a 32.768 kHz enable. With a value of 1 each pulse is a full second. The block also drives a square wave at one cycle per second from the same prescaler.

A host loads any field through a single-cycle write port and reads any field combinationally through a separate read address. The hours byte holds either a 24-hour value or a 12-hour value with a PM flag. Carries ripple from seconds through to the year. The block handles month lengths and leap years itself.

A halt flag shares the seconds byte. A write to the seconds byte restarts the sub-second prescaler, so software can align the second boundary with the moment it sets the time.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour), day of week 0x01, date 0x01, month 0x01 and year 0x00. The halt flag is clear and `sq_out` is 0.
- R2: Seconds and minutes count in BCD from 0x00 to 0x59. Each wraps to 0x00 and carries into the next field. Field addresses are 0 for seconds and 1 for minutes.
- R3: The hours byte at address 2 has bit 6 = 0 in 24-hour mode and counts BCD 0x00 to 0x23. Because the value is BCD, bit 5 is the tens digit for hours 20 to 23. The step from 0x23 to 0x00 advances the calendar by one day.
- R4: When bit 6 of the hours byte is 1, the hour is 12-hour time: bit 5 = 1 means PM and bits 4:0 hold BCD 01 to 12. 11 steps to 12 and toggles PM. 12 steps to 01 and keeps PM. Only the step from 11 PM to 12 AM advances the calendar.
- R5: The day of week (address 3, values 1 to 7) increments on each calendar advance, and 7 wraps to 1.
- R6: The date (address 4) wraps to 0x01 after the last day of its month. The month (address 5) wraps from 0x12 to 0x01. The year (address 6) wraps from 0x99 to 0x00. April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4 and 28 days otherwise. All other months have 31 days.
- R7: Bit 7 of the seconds byte is a halt flag. While it is 1, no field changes and the prescaler does not count.
- R8: A write to the seconds byte clears the prescaler. The seconds value then changes on the `TICKS_PER_SEC`-th counted tick after the write, however ticks are spaced.
- R9: `sq_out` is 0 after a seconds write. It goes to 1 once `TICKS_PER_SEC/2` ticks have been counted, and returns to 0 at the second boundary.
- R10: Unused bits read 0. Writes keep only seconds bits 6:0 (plus the halt flag in bit 7), minutes 6:0, hours 6:0, day of week 2:0, date 5:0, month 4:0 and all 8 year bits. Address 7 reads 0x00.
- R11: If a write to any field other than seconds lands in the same cycle as a second boundary, the written field takes the written value and the other fields advance as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset to the power-on value |
| tick_en | input | 1 | Prescaler count enable, one pulse per time base period |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field address for the write |
| wr_data | input | 8 | BCD write data |
| rd_addr | input | 3 | Field address for the read |
| rd_data | output | 8 | Addressed field, combinational |
| sq_out | output | 1 | Once-per-second square wave |

## Verification
Wrong carry or month-length state inside the block shows up on `rd_data` at the next second boundary, when the next higher field takes a wrong value. A leap-year or 30-day error therefore appears only on the boundary out of 23:59:59, or out of 11:59:59 PM, on the affected date, so the bench loads those instants directly. A prescaler that is off by one, or one that a seconds write fails to clear, shows on `sq_out` within half a second and on the seconds byte within one second. The reference model is compared on every clock, so such an error is caught in the cycle it first appears.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
   localparam int unsigned FIELD_W = 8;
   localparam int unsigned ADDR_W  = 3;

   typedef enum logic [ADDR_W-1:0] {
      F_SEC  = 3'd0,
      F_MIN  = 3'd1,
      F_HOUR = 3'd2,
      F_WDAY = 3'd3,
      F_MDAY = 3'd4,
      F_MON  = 3'd5,
      F_YEAR = 3'd6,
      F_NONE = 3'd7
   } field_e;

   // BCD increment of a two-digit value, no wrap handling
   function automatic logic [FIELD_W-1:0] bcd_step(input logic [FIELD_W-1:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
   parameter int unsigned TICKS_PER_SEC = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic run,
   input  logic restart,
   output logic sec_pulse,
   output logic sq
);
   localparam int unsigned CW   = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
   localparam int unsigned HALF = TICKS_PER_SEC / 2;

   if (TICKS_PER_SEC < 1) begin : g_bad_rate
      $error("cal_prescaler: TICKS_PER_SEC must be at least 1");
   end

   if (TICKS_PER_SEC == 1) begin : g_direct
      logic tog_q;
      assign sec_pulse = tick_en & run & ~restart;
      always_ff @(posedge clk) begin
         if (!rst_n)         tog_q <= 1'b0;
         else if (restart)   tog_q <= 1'b0;
         else if (sec_pulse) tog_q <= ~tog_q;
      end
      assign sq = tog_q;
   end else begin : g_div
      localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                cnt_q <= '0;
         else if (restart)          cnt_q <= '0;
         else if (tick_en && run)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      assign sec_pulse = tick_en & run & ~restart & (cnt_q == LAST);
      assign sq        = (cnt_q >= CW'(HALF));
   end
endmodule

// File: rtl/cal_bcd_wrap.sv
module cal_bcd_wrap
   import bcd_cal_pkg::*;
#(
   parameter logic [FIELD_W-1:0] FIRST = 8'h00
) (
   input  logic [FIELD_W-1:0] cur,
   input  logic [FIELD_W-1:0] last,
   output logic [FIELD_W-1:0] nxt,
   output logic               wrap
);
   assign wrap = (cur == last);
   assign nxt  = wrap ? FIRST : bcd_step(cur);
endmodule

// File: rtl/cal_hour_step.sv
module cal_hour_step (
   input  logic [6:0] hr,
   output logic [6:0] nxt,
   output logic       day_carry
);
   logic       mode12;
   logic       pm;
   logic [4:0] h12_inc;
   logic [5:0] h24_inc;

   assign mode12  = hr[6];
   assign pm      = hr[5];
   assign h12_inc = (hr[3:0] == 4'd9) ? 5'h10 : {hr[4], hr[3:0] + 4'd1};
   assign h24_inc = (hr[3:0] == 4'd9) ? {hr[5:4] + 2'd1, 4'd0} : {hr[5:4], hr[3:0] + 4'd1};

   always_comb begin
      day_carry = 1'b0;
      if (mode12) begin
         if (hr[4:0] == 5'h11) begin
            nxt       = {1'b1, ~pm, 5'h12};
            day_carry = pm;
         end else if (hr[4:0] == 5'h12) begin
            nxt = {1'b1, pm, 5'h01};
         end else begin
            nxt = {1'b1, pm, h12_inc};
         end
      end else if (hr[5:0] == 6'h23) begin
         nxt       = 7'h00;
         day_carry = 1'b1;
      end else begin
         nxt = {1'b0, h24_inc};
      end
   end
endmodule

// File: rtl/cal_month_days.sv
module cal_month_days
   import bcd_cal_pkg::*;
(
   input  logic [FIELD_W-1:0] mon,
   input  logic [FIELD_W-1:0] yr,
   output logic [FIELD_W-1:0] last_day
);
   logic [6:0] yr_bin;
   logic       leap;

   assign yr_bin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
   assign leap   = (yr_bin[1:0] == 2'b00);

   always_comb begin
      case (mon)
         8'h02:                      last_day = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
         default:                    last_day = 8'h31;
      endcase
   end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
   import bcd_cal_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 32768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              sq_out
);
   // counter fields in carry order: sec, min, wday, mday, mon, year
   localparam int unsigned NF = 6;
   localparam logic [NF*8-1:0] FIRSTS = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
   localparam logic [NF*8-1:0] MASKS  = {8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h7F, 8'h7F};
   localparam logic [NF*3-1:0] ADDRS  = {F_YEAR, F_MON, F_MDAY, F_WDAY, F_MIN, F_SEC};

   logic [NF-1:0][7:0] fld_q;
   logic [NF-1:0][7:0] f_last;
   logic [NF-1:0][7:0] f_nxt;
   logic [NF-1:0]      f_wrap;
   logic [NF-1:0]      f_en;
   logic [7:0]         hr_q;
   logic [6:0]         hr_nxt;
   logic               hr_en;
   logic               day_carry;
   logic               halt_q;
   logic               sec_wr;
   logic               sec_pulse;
   logic [7:0]         mday_last;

   assign sec_wr = wr_en && (wr_addr == F_SEC);

   cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(~halt_q),
      .restart(sec_wr), .sec_pulse(sec_pulse), .sq(sq_out)
   );

   cal_month_days u_mdays (.mon(fld_q[4]), .yr(fld_q[5]), .last_day(mday_last));

   cal_hour_step u_hour (.hr(hr_q[6:0]), .nxt(hr_nxt), .day_carry(day_carry));

   assign f_last = {8'h99, 8'h12, mday_last, 8'h07, 8'h59, 8'h59};

   // carry chain
   assign f_en[0] = sec_pulse;
   assign f_en[1] = f_en[0] & f_wrap[0];
   assign hr_en   = f_en[1] & f_wrap[1];
   assign f_en[2] = hr_en & day_carry;
   assign f_en[3] = hr_en & day_carry;
   assign f_en[4] = f_en[3] & f_wrap[3];
   assign f_en[5] = f_en[4] & f_wrap[4];

   for (genvar i = 0; i < NF; i++) begin : g_field
      cal_bcd_wrap #(.FIRST(FIRSTS[i*8 +: 8])) u_wrap (
         .cur(fld_q[i]), .last(f_last[i]), .nxt(f_nxt[i]), .wrap(f_wrap[i])
      );
      always_ff @(posedge clk) begin
         if (!rst_n)
            fld_q[i] <= FIRSTS[i*8 +: 8];
         else if (wr_en && (wr_addr == ADDRS[i*3 +: 3]))
            fld_q[i] <= wr_data & MASKS[i*8 +: 8];
         else if (f_en[i])
            fld_q[i] <= f_nxt[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hr_q   <= 8'h00;
         halt_q <= 1'b0;
      end else begin
         if (wr_en && (wr_addr == F_HOUR)) hr_q <= wr_data & 8'h7F;
         else if (hr_en)                   hr_q <= {1'b0, hr_nxt};
         if (sec_wr) halt_q <= wr_data[7];
      end
   end

   always_comb begin
      case (rd_addr)
         F_SEC:   rd_data = fld_q[0] | {halt_q, 7'b0};
         F_MIN:   rd_data = fld_q[1];
         F_HOUR:  rd_data = hr_q;
         F_WDAY:  rd_data = fld_q[2];
         F_MDAY:  rd_data = fld_q[3];
         F_MON:   rd_data = fld_q[4];
         F_YEAR:  rd_data = fld_q[5];
         default: rd_data = 8'h00;
      endcase
   end
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [2:0] wr_addr,
   input logic       sec_pulse,
   input logic       halt_q,
   input logic [7:0] sec_v,
   input logic [7:0] wday_v,
   input logic [7:0] mday_v,
   input logic       sq_out,
   input logic [2:0] rd_addr,
   input logic [7:0] rd_data
);
   p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && sec_v == 8'h59 && !wr_en) |=> (sec_v == 8'h00));

   p_wday_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wday_v != 8'h00);

   p_mday_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mday_v != 8'h00);

   p_no_pulse_halted_r7: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> !sec_pulse);

   p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_q && !wr_en) |=> $stable(sec_v));

   p_sq_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 3'd0) |=> !sq_out);

   p_unused_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == 3'd7) |-> (rd_data == 8'h00));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .sec_pulse(sec_pulse), .halt_q(halt_q), .sec_v(fld_q[0]),
   .wday_v(fld_q[2]), .mday_v(fld_q[3]), .sq_out(sq_out),
   .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
   localparam int P = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       sq_out;

   int n_chk = 0;
   int n_fail = 0;
   int cyc_n = 0;

   // reference model state
   int m_sec = 0, m_min = 0, m_hr = 0, m_dow = 1, m_date = 1, m_mon = 1, m_yr = 0;
   bit m_12 = 0, m_pm = 0, m_halt = 0;
   int m_pre = 0;

   bcd_calendar #(.TICKS_PER_SEC(P)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .sq_out(sq_out)
   );

   always #10 clk = ~clk;

   function automatic int tobcd(int x);
      return (x / 10) * 16 + (x % 10);
   endfunction

   function automatic int frombcd(int d);
      return (d / 16) * 10 + (d % 16);
   endfunction

   function automatic int enc(int a);
      case (a)
         0: return (m_halt ? 128 : 0) + tobcd(m_sec);
         1: return tobcd(m_min);
         2: return m_12 ? (64 + (m_pm ? 32 : 0) + tobcd(m_hr)) : tobcd(m_hr);
         3: return m_dow;
         4: return tobcd(m_date);
         5: return tobcd(m_mon);
         6: return tobcd(m_yr);
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(int a);
      case (a)
         0, 1: return "R2";
         2: return "R3 R4";
         3: return "R5";
         4, 5, 6: return "R6";
         default: return "R10";
      endcase
   endfunction

   function automatic int mlen();
      if (m_mon == 2) return (m_yr % 4 == 0) ? 29 : 28;
      if (m_mon == 4 || m_mon == 6 || m_mon == 9 || m_mon == 11) return 30;
      return 31;
   endfunction

   task automatic new_day();
      m_dow = (m_dow == 7) ? 1 : m_dow + 1;
      if (m_date == mlen()) begin
         m_date = 1;
         if (m_mon == 12) begin
            m_mon = 1;
            m_yr = (m_yr + 1) % 100;
         end else m_mon++;
      end else m_date++;
   endtask

   task automatic advance();
      m_sec++;
      if (m_sec < 60) return;
      m_sec = 0;
      m_min++;
      if (m_min < 60) return;
      m_min = 0;
      if (m_12) begin
         if (m_hr == 11) begin
            m_hr = 12;
            m_pm = !m_pm;
            if (!m_pm) new_day();
         end else if (m_hr == 12) m_hr = 1;
         else m_hr++;
      end else begin
         if (m_hr == 23) begin
            m_hr = 0;
            new_day();
         end else m_hr++;
      end
   endtask

   task automatic model_write(int a, int d);
      case (a)
         0: begin m_halt = d[7]; m_sec = frombcd(d & 'h7F); m_pre = 0; end
         1: m_min = frombcd(d & 'h7F);
         2: begin
            m_12 = d[6];
            m_pm = m_12 ? d[5] : 1'b0;
            m_hr = m_12 ? frombcd(d & 'h1F) : frombcd(d & 'h3F);
         end
         3: m_dow = d & 'h07;
         4: m_date = frombcd(d & 'h3F);
         5: m_mon = frombcd(d & 'h1F);
         6: m_yr = frombcd(d & 'hFF);
         default: ;
      endcase
   endtask

   task automatic model_next(bit t, bit w, int a, int d);
      bit sw;
      sw = w && (a == 0);
      if (t && !m_halt && !sw) begin
         if (m_pre == P - 1) begin
            m_pre = 0;
            advance();
         end else m_pre++;
      end
      if (w) model_write(a, d);
   endtask

   task automatic check(bit ok, string tag, int act, int exp, string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // one clock: compare against the model, then drive the next inputs
   task automatic cyc(bit t, bit w, int a, int d);
      int ra;
      @(negedge clk);
      check(sq_out == (m_pre >= P / 2), "R9", int'(sq_out), int'(m_pre >= P / 2), "model sq_out");
      ra = cyc_n % 8;
      rd_addr = 3'(ra);
      #1;
      check(int'(rd_data) == enc(ra), tag_of(ra), int'(rd_data), enc(ra), "model field");
      cyc_n++;
      tick_en = t;
      wr_en = w;
      wr_addr = 3'(a);
      wr_data = 8'(d);
      model_next(t, w, a, d);
   endtask

   task automatic set(int a, int d);
      cyc(0, 1, a, d);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
   endtask

   task automatic run_gap(int n);
      for (int i = 0; i < n; i++) begin
         cyc(1, 0, 0, 0);
         cyc(0, 0, 0, 0);
      end
   endtask

   task automatic peek(int a, int exp, string tag);
      cyc(0, 0, 0, 0);
      rd_addr = 3'(a);
      #1;
      check(int'(rd_data) == exp, tag, int'(rd_data), exp, "field read");
   endtask

   task automatic peek_sq(bit exp, string tag);
      cyc(0, 0, 0, 0);
      check(sq_out == exp, tag, int'(sq_out), int'(exp), "sq_out");
   endtask

   task automatic load(int hr, int mi, int se, int dw, int dt, int mo, int yr);
      set(0, 'h80);
      set(1, mi);
      set(2, hr);
      set(3, dw);
      set(4, dt);
      set(5, mo);
      set(6, yr);
      set(0, se);
   endtask

   initial begin
      #4_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 power-on value
      peek(0, 'h00, "R1");
      peek(1, 'h00, "R1");
      peek(2, 'h00, "R1");
      peek(3, 'h01, "R1");
      peek(4, 'h01, "R1");
      peek(5, 'h01, "R1");
      peek(6, 'h00, "R1");
      peek_sq(1'b0, "R1");

      // R2 minute carry
      load('h12, 'h34, 'h59, 3, 'h15, 'h07, 'h20);
      run(P);
      peek(0, 'h00, "R2");
      peek(1, 'h35, "R2");
      peek(2, 'h12, "R2");

      // R3 R5 R6 midnight into March, non-leap year
      load('h23, 'h59, 'h58, 7, 'h28, 'h02, 'h23);
      run(P);
      peek(2, 'h23, "R3");
      peek(0, 'h59, "R2");
      run(P);
      peek(0, 'h00, "R2");
      peek(1, 'h00, "R2");
      peek(2, 'h00, "R3");
      peek(3, 'h01, "R5");
      peek(4, 'h01, "R6");
      peek(5, 'h03, "R6");

      // R6 leap February
      load('h23, 'h59, 'h59, 2, 'h28, 'h02, 'h24);
      run(P);
      peek(4, 'h29, "R6");
      peek(5, 'h02, "R6");
      peek(3, 'h03, "R5");
      load('h23, 'h59, 'h59, 3, 'h29, 'h02, 'h24);
      run(P);
      peek(4, 'h01, "R6");
      peek(5, 'h03, "R6");

      // R6 thirty-day month, 31-day month, year wrap
      load('h23, 'h59, 'h59, 4, 'h30, 'h04, 'h10);
      run(P);
      peek(4, 'h01, "R6");
      peek(5, 'h05, "R6");
      load('h23, 'h59, 'h59, 4, 'h30, 'h01, 'h10);
      run(P);
      peek(4, 'h31, "R6");
      load('h23, 'h59, 'h59, 5, 'h31, 'h12, 'h99);
      run(P);
      peek(4, 'h01, "R6");
      peek(5, 'h01, "R6");
      peek(6, 'h00, "R6");
      peek(3, 'h06, "R5");

      // R4 twelve-hour steps
      load('h51, 'h59, 'h59, 1, 'h10, 'h06, 'h05);
      run(P);
      peek(2, 'h72, "R4");
      peek(4, 'h10, "R4");
      load('h72, 'h59, 'h59, 1, 'h10, 'h06, 'h05);
      run(P);
      peek(2, 'h61, "R4");
      load('h71, 'h59, 'h59, 1, 'h10, 'h06, 'h05);
      run(P);
      peek(2, 'h52, "R4");
      peek(4, 'h11, "R4");
      peek(3, 'h02, "R5");

      // R7 halt
      load('h08, 'h20, 'h10, 1, 'h05, 'h05, 'h05);
      run(3);
      set(0, 'h95);
      run(3 * P);
      peek(0, 'h95, "R7");
      peek(1, 'h20, "R7");
      peek_sq(1'b0, "R7");

      // R8 R9 restart with spaced ticks
      set(0, 'h30);
      run_gap(P / 2 - 1);
      peek_sq(1'b0, "R9");
      run_gap(1);
      peek_sq(1'b1, "R9");
      run_gap(P / 2 - 1);
      peek(0, 'h30, "R8");
      run_gap(1);
      peek(0, 'h31, "R8");
      peek_sq(1'b0, "R9");
      run(3);
      set(0, 'h40);
      run(P - 1);
      peek(0, 'h40, "R8");
      run(1);
      peek(0, 'h41, "R8");

      // R11 write on a second boundary
      load('h08, 'h20, 'h10, 1, 'h05, 'h05, 'h05);
      run(P - 1);
      cyc(1, 1, 1, 'h45);
      peek(1, 'h45, "R11");
      peek(0, 'h11, "R11");

      // R10 fixed-zero bits
      set(0, 'h80);
      set(3, 'hFF);
      peek(3, 'h07, "R10");
      set(5, 'hE9);
      peek(5, 'h09, "R10");
      set(4, 'hD5);
      peek(4, 'h15, "R10");
      set(1, 'hD9);
      peek(1, 'h59, "R10");
      peek(7, 'h00, "R10");
      run(2 * P);
      peek(0, 'h80, "R7");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule